// File: doc/BRIEF.md
# Frame-Sync Standby Detector with Clock-Rate Sense

This block watches the frame syncs of a two-channel serial voice port. Each channel has one transmit sync and one receive sync. The block decides when a channel has gone idle. It counts master clock cycles since the last sync pulse on each line. When both syncs of a channel have been silent for 500 µs, it raises that channel's standby flag, which downstream logic uses to gate power. When only one of the two has stopped, the channel is in an unsupported state. The block then raises an indeterminate flag for that channel and leaves its standby flag low.

The master clock runs at one of two rates, and one rate is twice the other. The same 500 µs is therefore 1024 cycles at the slow rate and 2048 cycles at the fast rate. While the power-up reset is held, the block measures the rate. It counts master clock cycles across a fixed number of periods of a slow, free-running reference tick. It compares that count with the midpoint of the two expected counts. It latches the verdict when reset is released and uses it to size both timeouts until the next reset.

Top module: `fs_standby_top`

## Requirements
- R1: While `por_n` is low, `standby`, `indet` and `rate_hi` are all 0.
- R2: During reset, `ref_tick` is sampled high on cycles t0, t1, t2 and so on, each sample being a tick. If at least `REF_TICKS`+1 ticks are seen and (t[`REF_TICKS`] − t0) > 1.5·`REF_TICKS`·`LO_CYC_PER_TICK`, then `rate_hi` is 1 from the first clock edge after `por_n` rises. Otherwise it is 0 from that edge.
- R3: After that first edge, `rate_hi` holds its value until the next reset, whatever `ref_tick` does.
- R4: A sync pulse is a clock edge where the sync input is sampled 1 and was sampled 0 on the edge before. After reset the previous sample counts as 0. A sync that stays high makes no further pulses.
- R5: Each sync line has a timeout limit of `TO_LO` cycles (1024) when `rate_hi`=0 and 2·`TO_LO` cycles when `rate_hi`=1. The line is timed out once that many clock edges have passed since its last pulse, or since reset if there has been none. A channel's `standby` is 1 exactly when both of its lines are timed out.
- R6: A pulse on either sync of a channel restarts that line's count. That channel's `standby` reads 0 right after the edge that captured the pulse.
- R7: A channel's `indet` is 1 exactly when one of its two lines is timed out and the other is not. `standby` and `indet` are never 1 together.
- R8: Channel 0 (`fsx_in[0]`, `fsr_in[0]`) and channel 1 (`fsx_in[1]`, `fsr_in[1]`) are timed independently, and neither affects the other's flags.
- R9: If reset is released before the measurement window completes (fewer than `REF_TICKS`+1 ticks), `rate_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| ref_tick | input | 1 | Free-running reference tick, one cycle wide, used only while reset is held |
| por_n | input | 1 | Power-up reset, active low, asynchronous assert |
| fsx_in | input | NUM_CH | Transmit frame sync per channel |
| fsr_in | input | NUM_CH | Receive frame sync per channel |
| standby | output | NUM_CH | Channel idle: both syncs timed out |
| rate_hi | output | 1 | Latched clock-rate verdict, 1 for the fast rate |
| indet | output | NUM_CH | Exactly one of the channel's syncs timed out |

## Verification
Two events can land on the same edge: a channel's timeout running out, and a wake pulse arriving. The bench silences both syncs of a channel together. It then follows its own model's gap count and injects a transmit pulse so that it is sampled on the very edge where the receive line reaches its limit. On that edge the channel must report indeterminate and not standby. The rate latch and a late reference tick are also made to coincide with normal operation, to show that the verdict stays frozen after reset.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  // Phases of the reset-time clock-rate measurement.
  typedef enum logic [1:0] {
    MTR_IDLE = 2'd0,
    MTR_RUN  = 2'd1,
    MTR_DONE = 2'd2
  } mtr_state_e;

endpackage

// File: rtl/fsb_rate_meter.sv
module fsb_rate_meter
  import fsb_pkg::*;
#(
  parameter int REF_TICKS       = 4,
  parameter int LO_CYC_PER_TICK = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic ref_tick,
  output logic rate_hi
);

  localparam int LO_CNT = REF_TICKS * LO_CYC_PER_TICK;
  localparam int HI_CNT = 2 * LO_CNT;
  localparam int THRESH = (LO_CNT + HI_CNT) / 2;
  localparam int CW     = $clog2(2 * HI_CNT + 1);
  localparam int TW     = $clog2(REF_TICKS + 1);

  localparam logic [CW-1:0] CNT_MAX = '1;

  mtr_state_e      st;
  logic [CW-1:0]   mcnt;
  logic [TW-1:0]   tcnt;
  logic            por_q;
  logic            fast;

  // The meter runs only while reset is held and is cleared once reset is released.
  always_ff @(posedge clk) begin
    if (por_n) begin
      st   <= MTR_IDLE;
      mcnt <= '0;
      tcnt <= '0;
    end else begin
      case (st)
        MTR_IDLE: begin
          if (ref_tick) begin
            st   <= MTR_RUN;
            mcnt <= '0;
            tcnt <= '0;
          end
        end
        MTR_RUN: begin
          if (mcnt != CNT_MAX) mcnt <= mcnt + 1'b1;
          if (ref_tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(REF_TICKS - 1)) st <= MTR_DONE;
          end
        end
        MTR_DONE: begin
          st <= MTR_DONE;
        end
        default: st <= MTR_IDLE;
      endcase
    end
  end

  assign fast = (st == MTR_DONE) && (mcnt > CW'(THRESH));

  // Capture the verdict on the first edge after release, then hold it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_q   <= 1'b0;
      rate_hi <= 1'b0;
    end else begin
      por_q <= 1'b1;
      if (!por_q) rate_hi <= fast;
    end
  end

endmodule

// File: rtl/fsb_sync_wd.sv
module fsb_sync_wd #(
  parameter int TO_LO = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic fs_in,
  input  logic rate_hi,
  output logic quiet
);

  localparam int TO_HI = 2 * TO_LO;
  localparam int W     = $clog2(TO_HI + 1);

  logic         fs_q;
  logic         pulse;
  logic [W-1:0] gap;
  logic [W-1:0] limit;

  assign limit = rate_hi ? W'(TO_HI) : W'(TO_LO);
  assign pulse = fs_in & ~fs_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fs_q <= 1'b0;
      gap  <= '0;
    end else begin
      fs_q <= fs_in;
      if (pulse)            gap <= '0;
      else if (gap < limit) gap <= gap + 1'b1;
    end
  end

  assign quiet = (gap >= limit);

endmodule

// File: rtl/fsb_chan.sv
module fsb_chan #(
  parameter int TO_LO = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic fsx,
  input  logic fsr,
  input  logic rate_hi,
  output logic standby,
  output logic indet
);

  logic quiet_x;
  logic quiet_r;

  fsb_sync_wd #(.TO_LO(TO_LO)) u_wd_x (
    .clk     (clk),
    .por_n   (por_n),
    .fs_in   (fsx),
    .rate_hi (rate_hi),
    .quiet   (quiet_x)
  );

  fsb_sync_wd #(.TO_LO(TO_LO)) u_wd_r (
    .clk     (clk),
    .por_n   (por_n),
    .fs_in   (fsr),
    .rate_hi (rate_hi),
    .quiet   (quiet_r)
  );

  assign standby = quiet_x & quiet_r;
  assign indet   = quiet_x ^ quiet_r;

endmodule

// File: rtl/fs_standby_top.sv
module fs_standby_top #(
  parameter int NUM_CH          = 2,
  parameter int TO_LO           = 1024,
  parameter int REF_TICKS       = 4,
  parameter int LO_CYC_PER_TICK = 64
) (
  input  logic              mclk,
  input  logic              ref_tick,
  input  logic              por_n,
  input  logic [NUM_CH-1:0] fsx_in,
  input  logic [NUM_CH-1:0] fsr_in,
  output logic [NUM_CH-1:0] standby,
  output logic              rate_hi,
  output logic [NUM_CH-1:0] indet
);

  fsb_rate_meter #(
    .REF_TICKS       (REF_TICKS),
    .LO_CYC_PER_TICK (LO_CYC_PER_TICK)
  ) u_meter (
    .clk      (mclk),
    .por_n    (por_n),
    .ref_tick (ref_tick),
    .rate_hi  (rate_hi)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fsb_chan #(.TO_LO(TO_LO)) u_chan (
      .clk     (mclk),
      .por_n   (por_n),
      .fsx     (fsx_in[c]),
      .fsr     (fsr_in[c]),
      .rate_hi (rate_hi),
      .standby (standby[c]),
      .indet   (indet[c])
    );
  end

endmodule

// File: rtl/fsb_standby_chk.sv
module fsb_standby_chk #(
  parameter int NUM_CH = 2
) (
  input logic              mclk,
  input logic              por_n,
  input logic [NUM_CH-1:0] fsx_in,
  input logic [NUM_CH-1:0] fsr_in,
  input logic [NUM_CH-1:0] standby,
  input logic              rate_hi,
  input logic [NUM_CH-1:0] indet
);

  logic              up_d;
  logic [NUM_CH-1:0] px;
  logic [NUM_CH-1:0] pr;
  logic [NUM_CH-1:0] rise_x;
  logic [NUM_CH-1:0] rise_r;

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n) begin
      up_d <= 1'b0;
      px   <= '0;
      pr   <= '0;
    end else begin
      up_d <= 1'b1;
      px   <= fsx_in;
      pr   <= fsr_in;
    end
  end

  assign rise_x = fsx_in & ~px;
  assign rise_r = fsr_in & ~pr;

  AST_RST_OUTS_LOW: assert property (@(posedge mclk)
    !por_n |-> (standby == '0 && indet == '0 && !rate_hi)); // R1

  AST_RATE_FROZEN: assert property (@(posedge mclk) disable iff (!por_n)
    up_d |=> $stable(rate_hi)); // R3

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ast
    AST_NOT_BOTH_FLAGS: assert property (@(posedge mclk) disable iff (!por_n)
      !(standby[c] && indet[c])); // R7

    AST_WAKE_CLEARS: assert property (@(posedge mclk) disable iff (!por_n)
      (rise_x[c] || rise_r[c]) |=> !standby[c]); // R6

    AST_STBY_HOLDS: assert property (@(posedge mclk) disable iff (!por_n)
      (standby[c] && !rise_x[c] && !rise_r[c]) |=> standby[c]); // R5
  end

endmodule

bind fs_standby_top fsb_standby_chk #(.NUM_CH(NUM_CH)) u_chk (
  .mclk    (mclk),
  .por_n   (por_n),
  .fsx_in  (fsx_in),
  .fsr_in  (fsr_in),
  .standby (standby),
  .rate_hi (rate_hi),
  .indet   (indet)
);

// File: tb/tb_fs_standby_top.sv
module tb_fs_standby_top;

  localparam int REF_T  = 4;
  localparam int LO_PER = 64;
  localparam int TO_L   = 1024;

  logic       mclk = 1'b0;
  logic       ref_tick = 1'b0;
  logic       por_n = 1'b1;
  logic [3:0] fs_drv = '0;   // 0:fsx0 1:fsr0 2:fsx1 3:fsr1
  logic [1:0] fsx_in, fsr_in;
  logic [1:0] standby, indet;
  logic       rate_hi;

  assign fsx_in = {fs_drv[2], fs_drv[0]};
  assign fsr_in = {fs_drv[3], fs_drv[1]};

  always #4 mclk = ~mclk;

  fs_standby_top #(
    .NUM_CH(2), .TO_LO(TO_L), .REF_TICKS(REF_T), .LO_CYC_PER_TICK(LO_PER)
  ) dut (
    .mclk(mclk), .ref_tick(ref_tick), .por_n(por_n),
    .fsx_in(fsx_in), .fsr_in(fsr_in),
    .standby(standby), .rate_hi(rate_hi), .indet(indet)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Stimulus controls
  bit en[4];
  bit hold[4];
  bit kick[4];
  int off[4];
  int frame_len = 256;
  int phase = 0;
  bit ref_en = 1'b0;
  int ref_per = 64;
  int ref_ph = 0;
  bit chk_on = 1'b0;

  // Behavioural reference model
  int cyc = 0;
  int m_cnt[4];
  bit m_prev[4];
  bit m_rate = 1'b0;
  bit m_up = 1'b0;
  int tq[$];

  function automatic int lim_now();
    return m_rate ? 2 * TO_L : TO_L;
  endfunction

  always @(posedge mclk) begin
    cyc++;
    if (!por_n) begin
      if (ref_tick) tq.push_back(cyc);
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_prev[i] = 1'b0; end
      m_rate = 1'b0;
      m_up = 1'b0;
    end else begin
      int lim;
      lim = lim_now();
      for (int i = 0; i < 4; i++) begin
        if (fs_drv[i] && !m_prev[i]) m_cnt[i] = 0;
        else if (m_cnt[i] < lim) m_cnt[i]++;
        m_prev[i] = fs_drv[i];
      end
      if (!m_up) begin
        m_rate = (tq.size() > REF_T) && ((tq[REF_T] - tq[0]) > (REF_T * LO_PER * 3) / 2);
        m_up = 1'b1;
      end
      tq.delete();
    end
  end

  // Per-cycle comparison, then input drive
  always @(negedge mclk) begin
    if (chk_on) begin
      for (int c = 0; c < 2; c++) begin
        bit qx, qr, es, ei;
        qx = por_n && (m_cnt[2*c]   >= lim_now());
        qr = por_n && (m_cnt[2*c+1] >= lim_now());
        es = qx & qr;
        ei = qx ^ qr;
        chk(standby[c] == es, "R5 standby vs model", standby[c], es);
        chk(indet[c] == ei, "R7 indet vs model", indet[c], ei);
      end
      chk(rate_hi == (por_n && m_rate), "R2 rate_hi vs model", rate_hi, por_n && m_rate);
    end
    phase = (phase + 1) % frame_len;
    for (int i = 0; i < 4; i++)
      fs_drv[i] = hold[i] | kick[i] | (en[i] && phase == off[i]);
    if (ref_en) begin
      ref_ph = (ref_ph + 1) % ref_per;
      ref_tick = (ref_ph == 0);
    end else begin
      ref_tick = 1'b0;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic do_reset(input int per, input int nticks);
    @(negedge mclk); #1;
    por_n = 1'b0;
    ref_per = per; ref_ph = 0; ref_en = 1'b1;
    chk_on = 1'b1;
    wait_cyc(per * nticks + per / 2);
    chk(standby == 2'b00 && indet == 2'b00 && rate_hi == 1'b0,
        "R1 outputs low in reset", {standby, indet, rate_hi}, 0);
    #1 ref_en = 1'b0;
    wait_cyc(2);
    #1 por_n = 1'b1;
    wait_cyc(2);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin en[i] = 1'b1; hold[i] = 1'b0; kick[i] = 1'b0; end
    off[0] = 10; off[1] = 10; off[2] = 50; off[3] = 90;
    wait_cyc(3);

    // ---- Slow clock ----
    do_reset(64, 6);
    chk(rate_hi == 1'b0, "R2 slow rate detected", rate_hi, 0);
    wait_cyc(1000);
    chk(standby == 2'b00 && indet == 2'b00, "R8 both channels active", {standby, indet}, 0);

    #1 en[0] = 1'b0; en[1] = 1'b0;
    wait_cyc(TO_L - 300);
    chk(standby[0] == 1'b0, "R5 not yet timed out", standby[0], 0);
    wait_cyc(600);
    chk(standby[0] == 1'b1, "R5 standby after slow timeout", standby[0], 1);
    chk(standby[1] == 1'b0 && indet[1] == 1'b0, "R8 channel 1 unaffected", {standby[1], indet[1]}, 0);

    @(negedge mclk); #1 kick[1] = 1'b1;
    @(negedge mclk); #1 kick[1] = 1'b0;
    @(negedge mclk);
    chk(standby[0] == 1'b0, "R6 wake pulse clears standby", standby[0], 0);
    chk(indet[0] == 1'b1, "R7 one sync still silent", indet[0], 1);

    #1 en[0] = 1'b1; en[1] = 1'b1;
    wait_cyc(600);
    chk(standby[0] == 1'b0 && indet[0] == 1'b0, "R7 channel 0 recovered", {standby[0], indet[0]}, 0);

    #1 hold[2] = 1'b1;
    wait_cyc(TO_L + 300);
    chk(indet[1] == 1'b1, "R4 held-high sync gives no pulses", indet[1], 1);
    chk(standby[1] == 1'b0, "R7 no standby with one sync alive", standby[1], 0);
    #1 hold[2] = 1'b0;
    wait_cyc(600);
    chk(indet[1] == 1'b0, "R4 edges resume after release", indet[1], 0);

    // ---- Fast clock ----
    frame_len = 512;
    do_reset(128, 6);
    chk(rate_hi == 1'b1, "R2 fast rate detected", rate_hi, 1);
    #1 ref_per = 64; ref_ph = 0; ref_en = 1'b1;
    wait_cyc(800);
    chk(rate_hi == 1'b1, "R3 verdict frozen despite ticks", rate_hi, 1);
    #1 ref_en = 1'b0;

    #1 en[2] = 1'b0; en[3] = 1'b0;
    wait_cyc(1500);
    chk(standby[1] == 1'b0, "R5 fast rate: no standby at 1500", standby[1], 0);
    wait_cyc(800);
    chk(standby[1] == 1'b1, "R5 fast rate: standby after 2048", standby[1], 1);
    chk(standby[0] == 1'b0, "R8 channel 0 still active", standby[0], 0);

    // Collision: wake pulse on the edge where the timeout expires
    #1 en[0] = 1'b0; en[1] = 1'b0;
    while (m_cnt[1] != 2 * TO_L - 2) @(negedge mclk);
    #1 kick[0] = 1'b1;
    @(negedge mclk); #1 kick[0] = 1'b0;
    @(negedge mclk);
    chk(standby[0] == 1'b0, "R6 pulse on expiry edge blocks standby", standby[0], 0);
    chk(indet[0] == 1'b1, "R7 collision leaves channel indeterminate", indet[0], 1);

    // ---- Incomplete measurement ----
    for (int i = 0; i < 4; i++) en[i] = 1'b1;
    do_reset(128, 3);
    chk(rate_hi == 1'b0, "R9 incomplete window selects slow", rate_hi, 0);
    wait_cyc(100);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule